// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the device-side serial port of a converter-style peripheral. An external host drives a serial clock, an active-low frame sync and a data-in line. A frame starts on the falling edge of sync and lasts exactly sixteen sampling edges of the serial clock. The two most significant bits of the frame are an address. The remaining fourteen bits are the payload. When the address selects the control register, the payload is decoded into a write-only set of control fields, and those fields are driven as outputs of the block. The convert-start and start-calibration bits are not stored. Each of them produces a single-cycle command pulse instead.

The same frames also carry data back to the host. A read-select field, written by an earlier frame, picks the word that is shifted out during the next frame: the latest conversion result, calibration data or the status word. All three words come from the converter core. A polarity input decides which serial clock edge samples data-in and which edge launches data-out. All logic runs on a fast system clock that oversamples the serial lines.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset every control output is 0, no command pulse is issued and `dout_oe` is 0.
- R2: A frame begins at a falling edge of `sync_n` and ends at its 16th sampling edge. Data-in is taken MSB first. Frame bits [15:14] equal to 11 select the control register. Within the payload, bits [9:8] map to `pwr_mode`, [7:6] to `rd_sel`, bit 5 to `two_wire_mode`, bit 3 to `cal_mode` and [2:1] to `cal_sel`.
- R3: A complete frame leaves the control outputs unchanged if its address is not 11 or if any reserved payload bit [13:10] is 1. A frame held entirely at 0 is one such frame.
- R4: `sync_n` need not rise after the 16th sampling edge. Further serial clocks are ignored until the next falling edge of `sync_n`.
- R5: If `sync_n` rises before the 16th sampling edge, the frame is discarded and the control outputs keep their values.
- R6: A control write with payload bit 4 set gives exactly one one-cycle `conv_start_pulse`. A control write with payload bit 0 set gives one one-cycle `cal_start_pulse`. Neither bit is retained.
- R7: The word shifted out MSB first during a frame is chosen by `rd_sel` as it stood when `sync_n` fell: 00 or 01 gives `conv_word`, 10 gives `cal_word`, 11 gives `status_word`.
- R8: With `polarity` = 1, data-in is sampled on rising `sclk` and data-out changes on falling `sclk`. With `polarity` = 0 the two edges swap.
- R9: `dout_oe` is 0 while `sync_n` is high, and it becomes 1 once `sync_n` is low.
- R10: Control outputs change only in the cycle after a completed control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sync_n | input | 1 | Active-low frame sync |
| din | input | 1 | Serial data from the host |
| polarity | input | 1 | Selects the sampling and launch edges of `sclk` |
| conv_word | input | 16 | Latest conversion result |
| status_word | input | 16 | Status word from the core |
| cal_word | input | 16 | Calibration data from the core |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for `dout` |
| pwr_mode | output | 2 | Power management field |
| rd_sel | output | 2 | Read-select field |
| two_wire_mode | output | 1 | Interface mode bit |
| cal_mode | output | 1 | Calibration mode bit |
| cal_sel | output | 2 | Calibration selection field |
| conv_start_pulse | output | 1 | One-cycle conversion start command |
| cal_start_pulse | output | 1 | One-cycle calibration start command |

## Verification
Frames are run under both polarities with four kinds of payload: a dense control write, an all-zero frame, a frame addressed elsewhere with every other bit set, and a control write with a reserved bit set. Comparing the control outputs after each kind separates address decoding from the reserved-bit guard. The read-back word of every complete frame passes through a scoreboard. The four read-select codes are stepped through, and the sequence shows both that the selection takes effect on the following frame and that code 01 behaves like 00. A frame aborted halfway and a frame followed by sixteen extra clocks with sync held low check that counting is anchored to the sync falling edge. The single command pulses are counted across writes that do and do not set the command bits.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int FRAME_W   = 16;
  localparam int ADDR_W    = 2;
  localparam int PAY_W     = FRAME_W - ADDR_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'b11;

  // payload bit positions, LSB = 0
  localparam int B_STCAL  = 0;
  localparam int B_CALSEL = 1;
  localparam int B_CALMD  = 3;
  localparam int B_CONV   = 4;
  localparam int B_MODE   = 5;
  localparam int B_RSEL   = 6;
  localparam int B_PWR    = 8;
  localparam int B_RSV    = 10;

  typedef enum logic [1:0] {
    RS_CONV     = 2'b00,
    RS_CONV_ALT = 2'b01,
    RS_CAL      = 2'b10,
    RS_STATUS   = 2'b11
  } rd_sel_e;

  typedef struct packed {
    logic [1:0] pwr;
    logic [1:0] rsel;
    logic       wire2;
    logic       calmd;
    logic [1:0] calsel;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [PAY_W-1:0] p);
    ctrl_t c;
    c.pwr    = p[B_PWR +: 2];
    c.rsel   = p[B_RSEL +: 2];
    c.wire2  = p[B_MODE];
    c.calmd  = p[B_CALMD];
    c.calsel = p[B_CALSEL +: 2];
    return c;
  endfunction

  function automatic logic reserved_clear(input logic [PAY_W-1:0] p);
    return p[PAY_W-1:B_RSV] == '0;
  endfunction

endpackage

// File: rtl/scr_sampler.sv
module scr_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sync_n,
  input  logic din,
  input  logic polarity,
  output logic sample_stb,
  output logic launch_stb,
  output logic sync_fall,
  output logic sync_rise,
  output logic sync_lvl,
  output logic din_s
);
  logic sclk_q, sclk_qq, sync_q, sync_qq;
  logic sclk_up, sclk_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      sync_q  <= 1'b1;
      sync_qq <= 1'b1;
      din_s   <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      sclk_qq <= sclk_q;
      sync_q  <= sync_n;
      sync_qq <= sync_q;
      din_s   <= din;
    end
  end

  assign sclk_up    = sclk_q & ~sclk_qq;
  assign sclk_dn    = ~sclk_q & sclk_qq;
  assign sample_stb = polarity ? sclk_up : sclk_dn;
  assign launch_stb = polarity ? sclk_dn : sclk_up;
  assign sync_fall  = sync_qq & ~sync_q;
  assign sync_rise  = ~sync_qq & sync_q;
  assign sync_lvl   = sync_q;
endmodule

// File: rtl/scr_frame.sv
module scr_frame #(
  parameter int FRAME_W = scr_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_stb,
  input  logic               launch_stb,
  input  logic               sync_fall,
  input  logic               sync_rise,
  input  logic               din_s,
  output logic               active,
  output logic               commit,
  output logic               tx_shift,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      rx     <= '0;
    end else if (sync_fall) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && sync_rise) begin
      active <= 1'b0;
    end else if (active && sample_stb) begin
      rx  <= {rx[FRAME_W-3:0], din_s};
      cnt <= cnt + 1'b1;
      if (cnt == LAST) active <= 1'b0;
    end
  end

  assign commit     = active && sample_stb && !sync_rise && !sync_fall && (cnt == LAST);
  assign frame_word = {rx, din_s};
  // first bit is presented at frame start; later bits after each sample
  assign tx_shift   = active && launch_stb && (cnt != '0);
endmodule

// File: rtl/scr_regs.sv
module scr_regs
  import scr_pkg::*;
#(
  parameter int FRAME_W = scr_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame_word,
  output ctrl_t              ctrl,
  output logic               conv_pulse,
  output logic               cal_pulse
);
  localparam int P_W = FRAME_W - ADDR_W;

  logic [ADDR_W-1:0] addr;
  logic [P_W-1:0]    payload;
  logic              write_hit;

  assign addr      = frame_word[FRAME_W-1 -: ADDR_W];
  assign payload   = frame_word[P_W-1:0];
  assign write_hit = commit && (addr == CTRL_ADDR) && reserved_clear(payload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      conv_pulse <= 1'b0;
      cal_pulse  <= 1'b0;
    end else begin
      conv_pulse <= write_hit && payload[B_CONV];
      cal_pulse  <= write_hit && payload[B_STCAL];
      if (write_hit) ctrl <= decode_ctrl(payload);
    end
  end
endmodule

// File: rtl/scr_tx.sv
module scr_tx
  import scr_pkg::*;
#(
  parameter int FRAME_W = scr_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [1:0]         sel,
  input  logic [FRAME_W-1:0] conv_word,
  input  logic [FRAME_W-1:0] status_word,
  input  logic [FRAME_W-1:0] cal_word,
  output logic               dout
);
  logic [FRAME_W-1:0] shreg;

  function automatic logic [FRAME_W-1:0] pick_word(
    input logic [1:0] s, input logic [FRAME_W-1:0] cv,
    input logic [FRAME_W-1:0] st, input logic [FRAME_W-1:0] cl);
    case (rd_sel_e'(s))
      RS_STATUS: return st;
      RS_CAL:    return cl;
      default:   return cv;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= pick_word(sel, conv_word, status_word, cal_word);
    else if (shift) shreg <= {shreg[FRAME_W-2:0], 1'b0};
  end

  assign dout = shreg[FRAME_W-1];
endmodule

// File: rtl/serial_ctl_port.sv
module serial_ctl_port
  import scr_pkg::*;
#(
  parameter int FRAME_W = scr_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sync_n,
  input  logic               din,
  input  logic               polarity,
  input  logic [FRAME_W-1:0] conv_word,
  input  logic [FRAME_W-1:0] status_word,
  input  logic [FRAME_W-1:0] cal_word,
  output logic               dout,
  output logic               dout_oe,
  output logic [1:0]         pwr_mode,
  output logic [1:0]         rd_sel,
  output logic               two_wire_mode,
  output logic               cal_mode,
  output logic [1:0]         cal_sel,
  output logic               conv_start_pulse,
  output logic               cal_start_pulse
);
  logic sample_stb, launch_stb, sync_fall, sync_rise, sync_lvl, din_s;
  logic frame_active, frame_commit, tx_shift;
  logic [FRAME_W-1:0] frame_word;
  ctrl_t ctrl;

  scr_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .polarity(polarity), .sample_stb(sample_stb), .launch_stb(launch_stb),
    .sync_fall(sync_fall), .sync_rise(sync_rise), .sync_lvl(sync_lvl),
    .din_s(din_s)
  );

  scr_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .launch_stb(launch_stb),
    .sync_fall(sync_fall), .sync_rise(sync_rise), .din_s(din_s),
    .active(frame_active), .commit(frame_commit), .tx_shift(tx_shift),
    .frame_word(frame_word)
  );

  scr_regs #(.FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(frame_commit), .frame_word(frame_word),
    .ctrl(ctrl), .conv_pulse(conv_start_pulse), .cal_pulse(cal_start_pulse)
  );

  scr_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(sync_fall), .shift(tx_shift),
    .sel(ctrl.rsel), .conv_word(conv_word), .status_word(status_word),
    .cal_word(cal_word), .dout(dout)
  );

  assign dout_oe       = ~sync_lvl;
  assign pwr_mode      = ctrl.pwr;
  assign rd_sel        = ctrl.rsel;
  assign two_wire_mode = ctrl.wire2;
  assign cal_mode      = ctrl.calmd;
  assign cal_sel       = ctrl.calsel;
endmodule

// File: rtl/serial_ctl_port_chk.sv
module serial_ctl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_n,
  input logic       dout_oe,
  input logic       frame_commit,
  input logic       frame_active,
  input logic       conv_start_pulse,
  input logic       cal_start_pulse,
  input logic [7:0] ctrl_bits
);
  a_r9_oe_off_sync_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_n) |-> !dout_oe);

  a_r10_ctrl_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_commit) |-> $stable(ctrl_bits));

  a_r6_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_pulse |=> !conv_start_pulse);

  a_r6_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_pulse |=> !cal_start_pulse);

  a_r6_pulse_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_pulse || cal_start_pulse) |-> $past(frame_commit));

  a_r4_idle_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |=> !frame_active);
endmodule

bind serial_ctl_port serial_ctl_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .dout_oe(dout_oe),
  .frame_commit(frame_commit), .frame_active(frame_active),
  .conv_start_pulse(conv_start_pulse), .cal_start_pulse(cal_start_pulse),
  .ctrl_bits({pwr_mode, rd_sel, two_wire_mode, cal_mode, cal_sel})
);

// File: tb/serial_ctl_port_bench.sv
`timescale 1ns/1ps
module serial_ctl_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sync_n = 1'b1, din = 1'b0, polarity = 1'b1;
  logic [15:0] conv_word = 16'hA5C3, status_word = 16'h3C0F, cal_word = 16'h1E69;
  logic dout, dout_oe, two_wire_mode, cal_mode, conv_start_pulse, cal_start_pulse;
  logic [1:0] pwr_mode, rd_sel, cal_sel;

  always #2.5 clk = ~clk;

  serial_ctl_port u_serial_ctl_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .din(din),
    .polarity(polarity), .conv_word(conv_word), .status_word(status_word),
    .cal_word(cal_word), .dout(dout), .dout_oe(dout_oe), .pwr_mode(pwr_mode),
    .rd_sel(rd_sel), .two_wire_mode(two_wire_mode), .cal_mode(cal_mode),
    .cal_sel(cal_sel), .conv_start_pulse(conv_start_pulse),
    .cal_start_pulse(cal_start_pulse)
  );

  int nchk = 0, nerr = 0;
  int conv_cnt = 0, cal_cnt = 0;
  bit done = 0;

  // bench model of the control fields: {pwr, rsel, mode, calmd, calsel}
  logic [7:0] m_ctrl = 8'h00;

  logic [15:0] exp_q[$];
  logic [15:0] cap_q[$];
  string       tag_q[$];
  event        frame_ev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] expect_word(input logic [1:0] rs);
    if (rs == 2'b11) return status_word;
    if (rs == 2'b10) return cal_word;
    return conv_word;
  endfunction

  task automatic check_ctrl(input string tag);
    chk(tag, {24'd0, pwr_mode, rd_sel, two_wire_mode, cal_mode, cal_sel}, {24'd0, m_ctrl});
  endtask

  // one sampling edge then one launch edge per bit
  task automatic clock_bit(input logic b, input logic pol, output logic seen);
    din = b; tick(4);
    seen = dout;
    sclk = pol; tick(4);
    sclk = ~pol; tick(4);
  endtask

  task automatic send_frame(input logic [15:0] w, input logic pol, input int abort_at,
                            input bit raise_sync, input string tag);
    logic [15:0] cap;
    logic [15:0] expw;
    logic seen;
    bit aborted;
    aborted = 0;
    cap = '0;
    polarity = pol; sclk = ~pol; tick(4);
    expw = expect_word(m_ctrl[5:4]);
    sync_n = 1'b0; tick(4);
    for (int i = 0; i < 16; i++) begin
      if (i == abort_at) begin
        sync_n = 1'b1; din = 1'b0; tick(6);
        aborted = 1;
        break;
      end
      clock_bit(w[15-i], pol, seen);
      cap = {cap[14:0], seen};
    end
    if (!aborted) begin
      if (w[15:14] == 2'b11 && w[13:10] == 4'b0000)
        m_ctrl = {w[9:8], w[7:6], w[5], w[3], w[2:1]};
      exp_q.push_back(expw);
      cap_q.push_back(cap);
      tag_q.push_back(tag);
      ->frame_ev;
      if (raise_sync) begin
        sync_n = 1'b1; din = 1'b0; tick(6);
      end
    end
  endtask

  // clocks after a full frame while sync stays low (R4)
  task automatic extra_clocks(input logic [15:0] w, input logic pol);
    logic seen;
    for (int i = 0; i < 16; i++) clock_bit(w[15-i], pol, seen);
  endtask

  // scoreboard monitor: compare each captured read-back word
  initial begin
    forever begin
      @(frame_ev);
      while (exp_q.size() > 0 && cap_q.size() > 0) begin
        chk(tag_q.pop_front(), {16'd0, cap_q.pop_front()}, {16'd0, exp_q.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    if (conv_start_pulse) conv_cnt++;
    if (cal_start_pulse)  cal_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    check_ctrl("R1 ctrl after reset");
    chk("R1 dout_oe after reset", {31'd0, dout_oe}, 32'd0);
    chk("R1 no pulses after reset", conv_cnt + cal_cnt, 0);

    // R2 dense control write; read-back still uses rsel 00 (R7)
    send_frame(16'hC2EA, 1'b1, 99, 1, "R7 readback conv rsel00");
    check_ctrl("R2 decode dense write");
    chk("R9 dout_oe low between frames", {31'd0, dout_oe}, 32'd0);

    // R3 all-zero frame, other address, reserved bit set
    send_frame(16'h0000, 1'b1, 99, 1, "R7 readback status rsel11");
    check_ctrl("R3 zero frame ignored");
    send_frame(16'hBFFF, 1'b1, 99, 1, "R7 readback status again");
    check_ctrl("R3 other address ignored");
    send_frame(16'hD2EA, 1'b1, 99, 1, "R7 readback status third");
    check_ctrl("R3 reserved bit ignored");

    // R8 opposite polarity write and read
    send_frame(16'hC080, 1'b0, 99, 1, "R8 readback status pol0");
    check_ctrl("R8 write with polarity low");
    send_frame(16'h0000, 1'b0, 99, 1, "R8 readback cal pol0 (R7)");

    // R6 convert start, rsel 01
    send_frame(16'hC050, 1'b1, 99, 1, "R7 readback cal rsel10");
    check_ctrl("R6 conv write fields");
    chk("R6 conv pulse count", conv_cnt, 1);
    chk("R6 no cal pulse", cal_cnt, 0);
    send_frame(16'h0000, 1'b1, 99, 1, "R7 readback conv rsel01");

    // R6 calibration start
    send_frame(16'hC001, 1'b1, 99, 1, "R7 readback conv before cal");
    chk("R6 cal pulse count", cal_cnt, 1);
    chk("R6 conv pulse unchanged", conv_cnt, 1);
    check_ctrl("R6 start bits not stored");

    // R5 aborted write
    send_frame(16'hC2EA, 1'b1, 8, 1, "R5 aborted");
    check_ctrl("R5 aborted frame discarded");
    send_frame(16'h0000, 1'b1, 99, 1, "R5 readback after abort");

    // R4 sync held low after 16 clocks
    send_frame(16'hC3C0, 1'b1, 99, 0, "R4 readback conv");
    extra_clocks(16'hC000, 1'b1);
    check_ctrl("R4 extra clocks ignored");
    sync_n = 1'b1; tick(6);
    send_frame(16'h0000, 1'b1, 99, 1, "R4 readback status next frame");
    check_ctrl("R4 state after next frame");

    tick(10);
    while (exp_q.size() > 0 && cap_q.size() > 0)
      chk(tag_q.pop_front(), {16'd0, cap_q.pop_front()}, {16'd0, exp_q.pop_front()});
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule